// File: doc/BRIEF.md
# Hybrid Mesh Route Computation with Channel-Class Ordering

This block is the route-computation stage of one router in a two-level network. The lower level is a wired 2-D mesh. The mesh is cut into square subnets, and each subnet holds exactly one router that also owns a radio port. The radio ports of these routers form a coarse mesh with one node per subnet. The block looks at the routing fields of a header flit and at the router's own identity, and in one registered step it returns three results: the output port, the virtual-channel class of the next hop, and the packet's updated phase. For a radio port it also returns the direction of the radio hop. Body flits are not routed here. Under wormhole switching they follow the port that was chosen for their header.

A packet that takes the radio path moves through three phases, and only in one direction. In phase UP it rides the UP wired class toward its own subnet's radio router. In phase RADIO it crosses subnets over the radio mesh, X first and then Y. In phase DOWN it rides the DOWN wired class to its destination. A packet that stays on wires is injected directly in phase DOWN. A header whose phase does not fit the router it reached is flagged and sent to the local port.

The output port codes are 0 local, 1 north (+y), 2 south (-y), 3 east (+x), 4 west (-x) and 5 radio. The phase codes are 0 UP, 1 RADIO, 2 DOWN and 3 invalid. The global coordinate of a router is subnet index × SIDE + local index, computed separately for each axis.

Top module: `hyb_route_calc`

## Requirements
- R1: Each result is registered. `out_valid` is high exactly in the cycle after a cycle with `in_valid` high, and the result fields in that cycle belong to that header.
- R2: In phase DOWN the port is chosen by XY routing toward the destination's global coordinate. X is corrected first: east (3) if the destination x is larger, west (4) if it is smaller. Only then is Y corrected: north (1) if larger, south (2) if smaller. `out_vc` is 1 (DOWN) and `out_phase` is 2.
- R3: A header in phase DOWN whose destination global coordinate equals the router's own coordinate goes to the local port (0).
- R4: A header in phase UP with the path flag set, at a router that is not at its subnet's radio-router coordinate, is routed by XY toward that coordinate. `out_vc` is 0 (UP) and `out_phase` stays 0.
- R5: A header in phase UP with the path flag set, arriving at the radio router (`my_is_wr`=1 and at the radio-router coordinate), leaves on the radio port (5) with `out_phase` 1 when the destination subnet differs from the router's subnet.
- R6: A header that reaches the radio router of the destination subnet in phase UP or RADIO switches to phase DOWN (2, `out_vc`=1). It is then routed as in R2 and R3.
- R7: On the radio port, `out_wdir` selects the neighbouring subnet. X is corrected first: 0 for +x, 1 for -x. Then Y: 2 for +y, 3 for -y.
- R8: The following cases are illegal: phase 3; phase RADIO at a router without a radio port; phase UP with the path flag clear; phase UP at the radio-router coordinate of a router without a radio port. Each raises `out_err` and routes to port 0 with `out_phase` 2 and `out_vc` 1.
- R9: The phase never moves backwards. A header in phase DOWN leaves in phase DOWN on a wired port, even at a radio router.
- R10: During and right after a synchronous reset, `out_valid` and `out_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Header fields are present this cycle |
| dst_sx | input | SB | Destination subnet x |
| dst_sy | input | SB | Destination subnet y |
| dst_lx | input | LB | Destination local x inside the subnet |
| dst_ly | input | LB | Destination local y inside the subnet |
| in_path | input | 1 | 1 = packet uses the radio path |
| in_phase | input | 2 | Phase carried in the header |
| my_sx | input | SB | This router's subnet x |
| my_sy | input | SB | This router's subnet y |
| my_lx | input | LB | This router's local x |
| my_ly | input | LB | This router's local y |
| my_is_wr | input | 1 | This router has a radio port |
| wr_lx | input | LB | Local x of this subnet's radio router |
| wr_ly | input | LB | Local y of this subnet's radio router |
| out_valid | output | 1 | Result is valid |
| out_port | output | 3 | Chosen output port |
| out_wdir | output | 2 | Radio hop direction (meaningful on port 5) |
| out_vc | output | 1 | Next-hop wired class: 0 UP, 1 DOWN |
| out_phase | output | 2 | Phase written back into the header |
| out_err | output | 1 | Illegal phase/router combination |

## Verification
Every result is due exactly one clock edge after the header is presented. The bench drives a header on a falling edge, lets one rising edge capture it, and compares all fields on the next falling edge, before it drives the next header. Idle cycles are checked in the same slot, to confirm that `out_valid` drops one edge after `in_valid`. The radio direction is compared only when port 5 is expected, because R7 defines it only there.

// File: rtl/hrc_pkg.sv
package hrc_pkg;
  typedef enum logic [2:0] {
    P_LOCAL    = 3'd0,
    P_NORTH    = 3'd1,
    P_SOUTH    = 3'd2,
    P_EAST     = 3'd3,
    P_WEST     = 3'd4,
    P_WIRELESS = 3'd5
  } port_e;

  typedef enum logic [1:0] {
    PH_UP  = 2'd0,
    PH_WL  = 2'd1,
    PH_DN  = 2'd2,
    PH_BAD = 2'd3
  } phase_e;

  // radio hop code from a mesh direction: +x 0, -x 1, +y 2, -y 3
  function automatic logic [1:0] wdir_of(port_e d);
    case (d)
      P_EAST:  return 2'd0;
      P_WEST:  return 2'd1;
      P_NORTH: return 2'd2;
      P_SOUTH: return 2'd3;
      default: return 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/hrc_flatten.sv
module hrc_flatten #(
  parameter int SB   = 2,
  parameter int LB   = 3,
  parameter int SIDE = 5,
  parameter int GW   = SB + LB
) (
  input  logic [SB-1:0] sub,
  input  logic [LB-1:0] loc,
  output logic [GW-1:0] g
);
  assign g = GW'(int'(sub) * SIDE + int'(loc));
endmodule

// File: rtl/hrc_xy_dir.sv
module hrc_xy_dir
  import hrc_pkg::*;
#(
  parameter int W = 5
) (
  input  logic [W-1:0] cur_x,
  input  logic [W-1:0] cur_y,
  input  logic [W-1:0] tgt_x,
  input  logic [W-1:0] tgt_y,
  output port_e        dir
);
  always_comb begin
    if (tgt_x > cur_x)      dir = P_EAST;
    else if (tgt_x < cur_x) dir = P_WEST;
    else if (tgt_y > cur_y) dir = P_NORTH;
    else if (tgt_y < cur_y) dir = P_SOUTH;
    else                    dir = P_LOCAL;
  end
endmodule

// File: rtl/hyb_route_calc.sv
module hyb_route_calc
  import hrc_pkg::*;
#(
  parameter int SB   = 2,
  parameter int LB   = 3,
  parameter int SIDE = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [SB-1:0] dst_sx,
  input  logic [SB-1:0] dst_sy,
  input  logic [LB-1:0] dst_lx,
  input  logic [LB-1:0] dst_ly,
  input  logic          in_path,
  input  logic [1:0]    in_phase,
  input  logic [SB-1:0] my_sx,
  input  logic [SB-1:0] my_sy,
  input  logic [LB-1:0] my_lx,
  input  logic [LB-1:0] my_ly,
  input  logic          my_is_wr,
  input  logic [LB-1:0] wr_lx,
  input  logic [LB-1:0] wr_ly,
  output logic          out_valid,
  output logic [2:0]    out_port,
  output logic [1:0]    out_wdir,
  output logic          out_vc,
  output logic [1:0]    out_phase,
  output logic          out_err
);
  localparam int GW   = SB + LB;
  localparam int NPT  = 3;  // points: 0 self, 1 destination, 2 radio router

  logic [SB-1:0] pt_sx [NPT];
  logic [SB-1:0] pt_sy [NPT];
  logic [LB-1:0] pt_lx [NPT];
  logic [LB-1:0] pt_ly [NPT];
  logic [GW-1:0] pt_gx [NPT];
  logic [GW-1:0] pt_gy [NPT];

  assign pt_sx[0] = my_sx;  assign pt_sy[0] = my_sy;
  assign pt_lx[0] = my_lx;  assign pt_ly[0] = my_ly;
  assign pt_sx[1] = dst_sx; assign pt_sy[1] = dst_sy;
  assign pt_lx[1] = dst_lx; assign pt_ly[1] = dst_ly;
  assign pt_sx[2] = my_sx;  assign pt_sy[2] = my_sy;
  assign pt_lx[2] = wr_lx;  assign pt_ly[2] = wr_ly;

  for (genvar i = 0; i < NPT; i++) begin : g_flat
    hrc_flatten #(.SB(SB), .LB(LB), .SIDE(SIDE), .GW(GW)) u_fx (
      .sub(pt_sx[i]), .loc(pt_lx[i]), .g(pt_gx[i]));
    hrc_flatten #(.SB(SB), .LB(LB), .SIDE(SIDE), .GW(GW)) u_fy (
      .sub(pt_sy[i]), .loc(pt_ly[i]), .g(pt_gy[i]));
  end

  port_e dir_wr, dir_dst, dir_sub;

  hrc_xy_dir #(.W(GW)) u_to_wr (
    .cur_x(pt_gx[0]), .cur_y(pt_gy[0]), .tgt_x(pt_gx[2]), .tgt_y(pt_gy[2]), .dir(dir_wr));
  hrc_xy_dir #(.W(GW)) u_to_dst (
    .cur_x(pt_gx[0]), .cur_y(pt_gy[0]), .tgt_x(pt_gx[1]), .tgt_y(pt_gy[1]), .dir(dir_dst));
  hrc_xy_dir #(.W(SB)) u_sub (
    .cur_x(my_sx), .cur_y(my_sy), .tgt_x(dst_sx), .tgt_y(dst_sy), .dir(dir_sub));

  logic   at_wr, same_sub;
  logic   n_err;
  port_e  n_port;
  phase_e n_phase;
  logic [1:0] n_wdir;

  assign at_wr    = (dir_wr == P_LOCAL);
  assign same_sub = (dir_sub == P_LOCAL);

  always_comb begin
    n_err   = 1'b0;
    n_port  = P_LOCAL;
    n_phase = phase_e'(in_phase);
    n_wdir  = 2'd0;
    case (phase_e'(in_phase))
      PH_UP: begin
        if (!in_path)          n_err = 1'b1;
        else if (!at_wr)       n_port = dir_wr;
        else if (!my_is_wr)    n_err = 1'b1;
        else if (same_sub) begin
          n_phase = PH_DN;
          n_port  = dir_dst;
        end else begin
          n_phase = PH_WL;
          n_port  = P_WIRELESS;
          n_wdir  = wdir_of(dir_sub);
        end
      end
      PH_WL: begin
        if (!my_is_wr)         n_err = 1'b1;
        else if (same_sub) begin
          n_phase = PH_DN;
          n_port  = dir_dst;
        end else begin
          n_port  = P_WIRELESS;
          n_wdir  = wdir_of(dir_sub);
        end
      end
      PH_DN:   n_port = dir_dst;
      default: n_err  = 1'b1;
    endcase
    if (n_err) begin
      n_port  = P_LOCAL;
      n_phase = PH_DN;
      n_wdir  = 2'd0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_port  <= P_LOCAL;
      out_wdir  <= 2'd0;
      out_vc    <= 1'b0;
      out_phase <= PH_UP;
      out_err   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_port  <= n_port;
        out_wdir  <= n_wdir;
        out_vc    <= (n_phase == PH_DN);
        out_phase <= n_phase;
        out_err   <= n_err;
      end
    end
  end

  // R1: result follows the header by exactly one edge
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r1_idle_drops: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R8: a flagged header always lands on the local port
  a_r8_err_local: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_err) |-> (out_port == P_LOCAL));
  // R9: DOWN never leaves DOWN
  a_r9_down_stays: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_phase == PH_DN) |=> (out_phase == PH_DN && out_port != P_WIRELESS));
  // R5: radio port only at a radio router
  a_r5_radio_only_wr: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !my_is_wr) |=> (out_port != P_WIRELESS));
  // R4: UP away from the radio router stays in UP
  a_r4_up_keeps_up: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_phase == PH_UP && in_path && !at_wr) |=> (out_phase == PH_UP && !out_vc));
endmodule

// File: tb/hyb_route_calc_bench.sv
module hyb_route_calc_bench;
  localparam int SB = 2, LB = 3, SIDE = 5;

  logic clk = 1'b0, rst = 1'b1;
  always #5 clk = ~clk;

  logic in_valid = 0, in_path = 0, my_is_wr = 0;
  logic [SB-1:0] dst_sx = 0, dst_sy = 0, my_sx = 0, my_sy = 0;
  logic [LB-1:0] dst_lx = 0, dst_ly = 0, my_lx = 0, my_ly = 0, wr_lx = 0, wr_ly = 0;
  logic [1:0] in_phase = 0;
  logic out_valid, out_vc, out_err;
  logic [2:0] out_port;
  logic [1:0] out_wdir, out_phase;

  int errors = 0, checks = 0;
  int e_port, e_wdir, e_vc, e_phase, e_err;
  string e_tag;

  hyb_route_calc #(.SB(SB), .LB(LB), .SIDE(SIDE)) u_hyb_route_calc (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .dst_sx(dst_sx), .dst_sy(dst_sy), .dst_lx(dst_lx), .dst_ly(dst_ly),
    .in_path(in_path), .in_phase(in_phase),
    .my_sx(my_sx), .my_sy(my_sy), .my_lx(my_lx), .my_ly(my_ly),
    .my_is_wr(my_is_wr), .wr_lx(wr_lx), .wr_ly(wr_ly),
    .out_valid(out_valid), .out_port(out_port), .out_wdir(out_wdir),
    .out_vc(out_vc), .out_phase(out_phase), .out_err(out_err));

  function automatic int xy(int cx, int cy, int tx, int ty);
    if (tx > cx) return 3;
    if (tx < cx) return 4;
    if (ty > cy) return 1;
    if (ty < cy) return 2;
    return 0;
  endfunction

  function automatic int hop(int d);
    case (d) 3: return 0; 4: return 1; 1: return 2; 2: return 3; default: return 0; endcase
  endfunction

  function automatic void model();
    int mx = int'(my_sx) * SIDE + int'(my_lx), my = int'(my_sy) * SIDE + int'(my_ly);
    int dx = int'(dst_sx) * SIDE + int'(dst_lx), dy = int'(dst_sy) * SIDE + int'(dst_ly);
    int wx = int'(my_sx) * SIDE + int'(wr_lx), wy = int'(my_sy) * SIDE + int'(wr_ly);
    bit here_wr = (mx == wx) && (my == wy);
    bit same = (my_sx == dst_sx) && (my_sy == dst_sy);
    e_err = 0; e_wdir = 0; e_phase = in_phase; e_port = 0;
    if (in_phase == 3 || (in_phase == 1 && !my_is_wr) || (in_phase == 0 && !in_path) ||
        (in_phase == 0 && here_wr && !my_is_wr)) begin
      e_err = 1; e_phase = 2; e_tag = "R8";
    end else if (in_phase == 2) begin
      e_port = xy(mx, my, dx, dy); e_tag = (e_port == 0) ? "R3" : "R2";
    end else if (in_phase == 0 && !here_wr) begin
      e_port = xy(mx, my, wx, wy); e_tag = "R4";
    end else if (same) begin
      e_phase = 2; e_port = xy(mx, my, dx, dy); e_tag = "R6";
    end else begin
      e_phase = 1; e_port = 5; e_tag = (in_phase == 0) ? "R5" : "R7";
      e_wdir = hop(xy(int'(my_sx), int'(my_sy), int'(dst_sx), int'(dst_sy)));
    end
    e_vc = (e_phase == 2) ? 1 : 0;
  endfunction

  task automatic set_hdr(int dsx, int dsy, int dlx, int dly, int path, int ph,
                         int msx, int msy, int mlx, int mly, int iswr, int wlx, int wly);
    dst_sx = SB'(dsx); dst_sy = SB'(dsy); dst_lx = LB'(dlx); dst_ly = LB'(dly);
    in_path = path[0]; in_phase = 2'(ph);
    my_sx = SB'(msx); my_sy = SB'(msy); my_lx = LB'(mlx); my_ly = LB'(mly);
    my_is_wr = iswr[0]; wr_lx = LB'(wlx); wr_ly = LB'(wly);
    in_valid = 1'b1;
  endtask

  task automatic run_check(string tag);
    model();
    @(negedge clk);
    checks++;
    if (!out_valid || out_port != 3'(e_port) || out_vc != e_vc[0] || out_phase != 2'(e_phase) ||
        out_err != e_err[0] || (e_port == 5 && out_wdir != 2'(e_wdir))) begin
      errors++;
      $display("FAIL %s/%s: got v=%0d port=%0d wdir=%0d vc=%0d ph=%0d err=%0d exp v=1 port=%0d wdir=%0d vc=%0d ph=%0d err=%0d",
               tag, e_tag, out_valid, out_port, out_wdir, out_vc, out_phase, out_err,
               e_port, e_wdir, e_vc, e_phase, e_err);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h1d2c);
    repeat (3) @(negedge clk);
    // R10: reset state
    checks++;
    if (out_valid !== 1'b0 || out_err !== 1'b0) begin
      errors++; $display("FAIL R10: got v=%0d err=%0d exp 0 0", out_valid, out_err);
    end
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_err !== 1'b0) begin
      errors++; $display("FAIL R10: got v=%0d err=%0d exp 0 0 after release", out_valid, out_err);
    end
    // R2 west first, then north
    set_hdr(1,2,0,0, 0,2, 1,1,2,2, 0,0,0); run_check("R2");
    set_hdr(1,2,2,0, 0,2, 1,1,2,2, 0,0,0); run_check("R2");
    set_hdr(1,0,2,4, 0,2, 1,1,2,2, 0,0,0); run_check("R2");
    // R3 destination reached
    set_hdr(1,1,2,2, 0,2, 1,1,2,2, 0,0,0); run_check("R3");
    // R4 toward own radio router
    set_hdr(3,3,0,0, 1,0, 0,0,0,0, 0,2,3); run_check("R4");
    set_hdr(3,3,0,0, 1,0, 0,0,2,0, 0,2,3); run_check("R4");
    // R5 launch on radio, Y only
    set_hdr(0,2,1,1, 1,0, 0,0,2,3, 1,2,3); run_check("R5");
    // R7 X first over radio
    set_hdr(0,3,1,1, 1,1, 2,1,1,1, 1,1,1); run_check("R7");
    set_hdr(2,0,1,1, 1,1, 2,1,1,1, 1,1,1); run_check("R7");
    // R6 exit radio in destination subnet
    set_hdr(1,1,4,2, 1,1, 1,1,2,2, 1,2,2); run_check("R6");
    set_hdr(1,1,2,2, 1,0, 1,1,2,2, 1,2,2); run_check("R6");
    // R8 illegal combinations
    set_hdr(0,0,0,0, 1,3, 1,1,1,1, 1,1,1); run_check("R8");
    set_hdr(2,2,0,0, 1,1, 1,1,1,1, 0,2,2); run_check("R8");
    set_hdr(2,2,0,0, 0,0, 1,1,1,1, 0,2,2); run_check("R8");
    set_hdr(2,2,0,0, 1,0, 1,1,2,2, 0,2,2); run_check("R8");
    // R9 DOWN at a radio router stays wired
    set_hdr(3,0,0,0, 0,2, 0,0,2,2, 1,2,2); run_check("R9");
    // R1 idle cycle
    in_valid = 1'b0;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++; $display("FAIL R1: got v=%0d exp 0", out_valid);
    end
    // random mix
    for (int n = 0; n < 600; n++) begin
      int msx = $urandom % 4, msy = $urandom % 4;
      int wlx = $urandom % SIDE, wly = $urandom % SIDE;
      int mlx = $urandom % SIDE, mly = $urandom % SIDE;
      int iswr = 0;
      int ph = ($urandom % 8 == 0) ? 3 : $urandom % 3;
      if ($urandom % 2 == 0) begin mlx = wlx; mly = wly; iswr = ($urandom % 8 != 0); end
      set_hdr($urandom % 4, $urandom % 4, $urandom % SIDE, $urandom % SIDE,
              ($urandom % 8 != 0), ph, msx, msy, mlx, mly, iswr, wlx, wly);
      run_check("R1");
    end
    in_valid = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule